// File: doc/BRIEF.md
# Synthesizer Serial Programming Word Loader

This block is the configuration port of a dual-loop frequency synthesizer. A host drives three wires: serial data, a serial clock and a latch strobe. Each rising edge of the serial clock moves one data bit into a 23-bit shift register. The block keeps only the most recent 23 bits. A rising edge on the latch strobe decodes the two routing bits at the head of the frame and copies the payload into one holding register. There are four holding registers, a reference-divider register and a main-divider register for each of the two loops.

All three wires are sampled by the block's own system clock and are assumed synchronous to it. An edge on a wire counts in the system clock cycle where the wire is first seen high after being low. The latched fields are available at all times on the outputs, one slice per loop. The main-divider fields are swallow count, program count, prescaler select, phase polarity and lock-detect select. The reference-divider fields are reference count, two test bits and charge-pump current select.

Top module: `synth_word_loader`

## Requirements
- R1: A data bit enters the shift register on each rising edge of `serClk`. The bit that arrives k-th, counting from 0, sits at frame position k after 23 bits. When more than 23 bits are clocked in, only the last 23 form the frame.
- R2: Holding registers change only in the cycle where a rising edge of `latchEn` is seen. They do not change while bits shift in, and they do not change while `latchEn` stays high.
- R3: Frame position 0 (the first bit sent) selects the register kind: 1 means main divider, 0 means reference divider. Position 1 selects the loop: 0 means loop 0, 1 means loop 1.
- R4: In a main-divider frame, position 2 is lock-detect select and position 3 is prescaler select. Position 4 is phase polarity. Positions 5..11 hold the swallow count and positions 12..22 hold the program count, each with its least significant bit first.
- R5: In a reference-divider frame, positions 2..3 are the test bits, low bit first. Positions 4..17 hold the reference count, least significant bit first. Position 18 is charge-pump select, where 1 means high current and 0 means low current. Positions 19..22 are ignored.
- R6: A main-divider frame whose program count is below 3 leaves every holding register unchanged. A program count of exactly 3 is accepted.
- R7: An active-low `rstN` clears every holding register to zero at once, without waiting for a clock edge.
- R8: The full field ranges are stored exactly: swallow 0..127, program 3..2047, reference 0..16383.
- R9: A write changes only the register its routing bits select. All other registers keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial wires |
| rstN | input | 1 | Asynchronous active-low reset |
| serClk | input | 1 | Serial bit clock; rising edge shifts one bit |
| serData | input | 1 | Serial data bit |
| latchEn | input | 1 | Latch strobe; rising edge commits the frame |
| swallowCnt | output | 14 | Swallow count, 7 bits per loop, loop 0 in the low slice |
| progCnt | output | 22 | Program count, 11 bits per loop |
| prescSel | output | 2 | Prescaler select, one bit per loop |
| phasePol | output | 2 | Phase polarity, one bit per loop |
| lockSel | output | 2 | Lock-detect output select, one bit per loop |
| refCnt | output | 28 | Reference count, 14 bits per loop |
| testBits | output | 4 | Test bits, 2 per loop |
| cpHigh | output | 2 | Charge-pump high-current select, one bit per loop |

## Verification
Every holding register is always visible on the outputs, so a wrong internal state shows within one system clock cycle of the latch edge. A misrouted write shows on another loop's slice in the same cycle. A misordered shift corrupts a field value. A premature copy shows while bits are still shifting, before the latch edge. After each commit the whole output state is compared to a model. The state is also compared in the middle of a shift, while the strobe is held high, and right after an asynchronous reset. This way a stale, early or stray update cannot pass unseen.

// File: rtl/wordload_pkg.sv
package wordload_pkg;
  localparam int LOOPS  = 2;
  localparam int SWAL_W = 7;
  localparam int PROG_W = 11;
  localparam int REF_W  = 14;
  localparam int TEST_W = 2;
  localparam int PROG_MIN = 3;

  typedef struct packed {
    logic             shift;
    logic [LOOPS-1:0] ldMain;
    logic [LOOPS-1:0] ldRef;
  } strobe_t;
endpackage

// File: rtl/wordload_ctrl.sv
module wordload_ctrl
  import wordload_pkg::*;
#(
  parameter int NUM_LOOPS = LOOPS,
  parameter int PROG_BITS = PROG_W,
  parameter int PROG_LOW  = PROG_MIN,
  localparam int DEST_W   = $clog2(2 * NUM_LOOPS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 serClk,
  input  logic                 latchEn,
  input  logic [DEST_W-1:0]    destCode,
  input  logic [PROG_BITS-1:0] progField,
  output strobe_t              strobe
);
  logic serClkQ, latchEnQ;
  logic clkRise, leRise;
  logic [DEST_W-2:0] loopSel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      serClkQ  <= 1'b0;
      latchEnQ <= 1'b0;
    end else begin
      serClkQ  <= serClk;
      latchEnQ <= latchEn;
    end
  end

  assign clkRise = serClk & ~serClkQ;
  assign leRise  = latchEn & ~latchEnQ;
  assign loopSel = destCode[DEST_W-1:1];

  always_comb begin
    strobe       = '0;
    strobe.shift = clkRise;
    if (leRise) begin
      if (!destCode[0])
        strobe.ldRef[loopSel] = 1'b1;
      else if (progField >= PROG_BITS'(PROG_LOW))
        strobe.ldMain[loopSel] = 1'b1;
    end
  end

  // R3
  one_dest_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.ldMain, strobe.ldRef}));
endmodule

// File: rtl/wordload_bank.sv
module wordload_bank #(
  parameter int SWAL_BITS = 7,
  parameter int PROG_BITS = 11,
  parameter int REF_BITS  = 14,
  parameter int TEST_BITS = 2,
  parameter int PROG_LOW  = 3,
  localparam int PAY_W    = 3 + SWAL_BITS + PROG_BITS,
  localparam int SW_LO    = 3,
  localparam int PG_LO    = SW_LO + SWAL_BITS,
  localparam int RC_LO    = TEST_BITS,
  localparam int CP_POS   = RC_LO + REF_BITS
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 ldMain,
  input  logic                 ldRef,
  input  logic [PAY_W-1:0]     payload,
  output logic [SWAL_BITS-1:0] swalQ,
  output logic [PROG_BITS-1:0] progQ,
  output logic                 prescQ,
  output logic                 phaseQ,
  output logic                 lockQ,
  output logic [REF_BITS-1:0]  refQ,
  output logic [TEST_BITS-1:0] testQ,
  output logic                 cpQ
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      swalQ  <= '0;
      progQ  <= '0;
      prescQ <= 1'b0;
      phaseQ <= 1'b0;
      lockQ  <= 1'b0;
    end else if (ldMain) begin
      lockQ  <= payload[0];
      prescQ <= payload[1];
      phaseQ <= payload[2];
      swalQ  <= payload[SW_LO +: SWAL_BITS];
      progQ  <= payload[PG_LO +: PROG_BITS];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refQ  <= '0;
      testQ <= '0;
      cpQ   <= 1'b0;
    end else if (ldRef) begin
      testQ <= payload[0 +: TEST_BITS];
      refQ  <= payload[RC_LO +: REF_BITS];
      cpQ   <= payload[CP_POS];
    end
  end

  // R2
  main_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ldMain |=> ($stable(progQ) && $stable(swalQ) && $stable(lockQ)));
  // R2
  ref_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ldRef |=> ($stable(refQ) && $stable(testQ) && $stable(cpQ)));
  // R6
  prog_floor_chk: assert property (@(posedge clk) disable iff (!rstN)
    ldMain |=> (progQ >= PROG_BITS'(PROG_LOW)));
endmodule

// File: rtl/wordload_path.sv
module wordload_path
  import wordload_pkg::*;
#(
  parameter int NUM_LOOPS = LOOPS,
  parameter int SWAL_BITS = SWAL_W,
  parameter int PROG_BITS = PROG_W,
  parameter int REF_BITS  = REF_W,
  parameter int TEST_BITS = TEST_W,
  parameter int PROG_LOW  = PROG_MIN,
  localparam int DEST_W   = $clog2(2 * NUM_LOOPS),
  localparam int PAY_W    = 3 + SWAL_BITS + PROG_BITS,
  localparam int WORD_W   = DEST_W + PAY_W
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           serData,
  input  strobe_t                        strobe,
  output logic [DEST_W-1:0]              destCode,
  output logic [PROG_BITS-1:0]           progField,
  output logic [NUM_LOOPS*SWAL_BITS-1:0] swallowCnt,
  output logic [NUM_LOOPS*PROG_BITS-1:0] progCnt,
  output logic [NUM_LOOPS-1:0]           prescSel,
  output logic [NUM_LOOPS-1:0]           phasePol,
  output logic [NUM_LOOPS-1:0]           lockSel,
  output logic [NUM_LOOPS*REF_BITS-1:0]  refCnt,
  output logic [NUM_LOOPS*TEST_BITS-1:0] testBits,
  output logic [NUM_LOOPS-1:0]           cpHigh
);
  logic [WORD_W-1:0] shiftReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      shiftReg <= '0;
    else if (strobe.shift)
      shiftReg <= {serData, shiftReg[WORD_W-1:1]};
  end

  assign destCode  = shiftReg[DEST_W-1:0];
  assign progField = shiftReg[WORD_W-1 -: PROG_BITS];

  for (genvar l = 0; l < NUM_LOOPS; l++) begin : g_loop
    wordload_bank #(
      .SWAL_BITS(SWAL_BITS), .PROG_BITS(PROG_BITS), .REF_BITS(REF_BITS),
      .TEST_BITS(TEST_BITS), .PROG_LOW(PROG_LOW)
    ) u_bank (
      .clk     (clk),
      .rstN    (rstN),
      .ldMain  (strobe.ldMain[l]),
      .ldRef   (strobe.ldRef[l]),
      .payload (shiftReg[WORD_W-1:DEST_W]),
      .swalQ   (swallowCnt[l*SWAL_BITS +: SWAL_BITS]),
      .progQ   (progCnt[l*PROG_BITS +: PROG_BITS]),
      .prescQ  (prescSel[l]),
      .phaseQ  (phasePol[l]),
      .lockQ   (lockSel[l]),
      .refQ    (refCnt[l*REF_BITS +: REF_BITS]),
      .testQ   (testBits[l*TEST_BITS +: TEST_BITS]),
      .cpQ     (cpHigh[l])
    );
  end

  // R1
  shift_in_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.shift |=> (shiftReg[WORD_W-1] == $past(serData)));
endmodule

// File: rtl/synth_word_loader.sv
module synth_word_loader
  import wordload_pkg::*;
#(
  parameter int NUM_LOOPS = LOOPS,
  parameter int SWAL_BITS = SWAL_W,
  parameter int PROG_BITS = PROG_W,
  parameter int REF_BITS  = REF_W,
  parameter int TEST_BITS = TEST_W,
  parameter int PROG_LOW  = PROG_MIN,
  localparam int DEST_W   = $clog2(2 * NUM_LOOPS)
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           serClk,
  input  logic                           serData,
  input  logic                           latchEn,
  output logic [NUM_LOOPS*SWAL_BITS-1:0] swallowCnt,
  output logic [NUM_LOOPS*PROG_BITS-1:0] progCnt,
  output logic [NUM_LOOPS-1:0]           prescSel,
  output logic [NUM_LOOPS-1:0]           phasePol,
  output logic [NUM_LOOPS-1:0]           lockSel,
  output logic [NUM_LOOPS*REF_BITS-1:0]  refCnt,
  output logic [NUM_LOOPS*TEST_BITS-1:0] testBits,
  output logic [NUM_LOOPS-1:0]           cpHigh
);
  strobe_t              strobe;
  logic [DEST_W-1:0]    destCode;
  logic [PROG_BITS-1:0] progField;

  wordload_ctrl #(
    .NUM_LOOPS(NUM_LOOPS), .PROG_BITS(PROG_BITS), .PROG_LOW(PROG_LOW)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .serClk(serClk), .latchEn(latchEn),
    .destCode(destCode), .progField(progField), .strobe(strobe)
  );

  wordload_path #(
    .NUM_LOOPS(NUM_LOOPS), .SWAL_BITS(SWAL_BITS), .PROG_BITS(PROG_BITS),
    .REF_BITS(REF_BITS), .TEST_BITS(TEST_BITS), .PROG_LOW(PROG_LOW)
  ) u_path (
    .clk(clk), .rstN(rstN), .serData(serData), .strobe(strobe),
    .destCode(destCode), .progField(progField),
    .swallowCnt(swallowCnt), .progCnt(progCnt), .prescSel(prescSel),
    .phasePol(phasePol), .lockSel(lockSel), .refCnt(refCnt),
    .testBits(testBits), .cpHigh(cpHigh)
  );
endmodule

// File: tb/tb_synth_word_loader.sv
module tb_synth_word_loader;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serClk = 1'b0, serData = 1'b0, latchEn = 1'b0;
  logic [13:0] swallowCnt;
  logic [21:0] progCnt;
  logic [1:0]  prescSel, phasePol, lockSel, cpHigh;
  logic [27:0] refCnt;
  logic [3:0]  testBits;

  int checks = 0, fails = 0;

  logic [13:0] mSwal; logic [21:0] mProg; logic [1:0] mPs, mPh, mLd, mCp;
  logic [27:0] mRef;  logic [3:0] mTest;

  logic [75:0] expQ[$];
  string       tagQ[$];

  always #2.5 clk = ~clk;

  synth_word_loader dut (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serData(serData), .latchEn(latchEn),
    .swallowCnt(swallowCnt), .progCnt(progCnt), .prescSel(prescSel),
    .phasePol(phasePol), .lockSel(lockSel), .refCnt(refCnt),
    .testBits(testBits), .cpHigh(cpHigh)
  );

  function automatic logic [75:0] dutVec();
    return {refCnt, testBits, cpHigh, swallowCnt, progCnt, prescSel, phasePol, lockSel};
  endfunction

  function automatic logic [75:0] modelVec();
    return {mRef, mTest, mCp, mSwal, mProg, mPs, mPh, mLd};
  endfunction

  task automatic clearModel();
    mSwal = '0; mProg = '0; mPs = '0; mPh = '0; mLd = '0;
    mRef = '0; mTest = '0; mCp = '0;
  endtask

  task automatic compare(input logic [75:0] exp, input string tag);
    logic [75:0] act = dutVec();
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Model per R3/R4/R5/R6: bit0 kind (1 main), bit1 loop
  task automatic applyWord(input logic [22:0] w);
    int l = int'(w[1]);
    if (!w[0]) begin
      mTest[l*2 +: 2]  = w[3:2];
      mRef[l*14 +: 14] = w[17:4];
      mCp[l]           = w[18];
    end else if (w[22:12] >= 11'd3) begin
      mLd[l] = w[2]; mPs[l] = w[3]; mPh[l] = w[4];
      mSwal[l*7 +: 7]  = w[11:5];
      mProg[l*11 +: 11] = w[22:12];
    end
  endtask

  function automatic logic [22:0] mkMain(input logic lp, input logic ld, input logic ps,
      input logic ph, input logic [6:0] sw, input logic [10:0] pg);
    return {pg, sw, ph, ps, ld, lp, 1'b1};
  endfunction

  function automatic logic [22:0] mkRef(input logic lp, input logic [1:0] t,
      input logic [13:0] rc, input logic cp, input logic [3:0] junk);
    return {junk, cp, rc, t, lp, 1'b0};
  endfunction

  task automatic shiftBits(input logic [31:0] v, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); serData = v[i]; serClk = 1'b0;
      @(negedge clk); serClk = 1'b1;
    end
    @(negedge clk); serClk = 1'b0;
  endtask

  task automatic pulseLe(input logic [22:0] w, input string tag, input bit hold = 0);
    @(negedge clk);
    applyWord(w);
    expQ.push_back(modelVec());
    tagQ.push_back(tag);
    latchEn = 1'b1;
    @(negedge clk);
    if (!hold) latchEn = 1'b0;
    @(negedge clk);
  endtask

  task automatic sendWord(input logic [22:0] w, input string tag);
    shiftBits({9'd0, w}, 23);
    pulseLe(w, tag);
  endtask

  // monitor: compares the committed state one edge after each latch strobe
  initial begin
    forever begin
      @(posedge latchEn);
      @(negedge clk);
      if (expQ.size() > 0) compare(expQ.pop_front(), tagQ.pop_front());
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [22:0] w;
    clearModel();
    repeat (3) @(negedge clk);
    compare(modelVec(), "R7 reset state");
    rstN = 1'b1;

    sendWord(mkMain(1'b0, 1'b1, 1'b0, 1'b1, 7'd5, 11'd100), "R3 R4 main loop0");
    sendWord(mkRef(1'b0, 2'b01, 14'h2AAA, 1'b1, 4'h0), "R5 ref loop0 high cp");
    sendWord(mkMain(1'b1, 1'b0, 1'b1, 1'b0, 7'd127, 11'd2047), "R8 main loop1 max");
    sendWord(mkRef(1'b1, 2'b10, 14'h3FFF, 1'b0, 4'hF), "R5 ref loop1 ignored bits");
    sendWord(mkMain(1'b0, 1'b0, 1'b1, 1'b0, 7'd99, 11'd2), "R6 program 2 rejected");
    sendWord(mkMain(1'b1, 1'b1, 1'b1, 1'b1, 7'd0, 11'd3), "R6 R8 program 3 accepted");
    sendWord(mkRef(1'b0, 2'b11, 14'd1, 1'b0, 4'h5), "R9 loop1 untouched");

    // R2: a fully shifted frame does not reach the outputs before the strobe
    w = mkMain(1'b0, 1'b1, 1'b1, 1'b1, 7'd64, 11'd1024);
    shiftBits({9'd0, w}, 23);
    compare(modelVec(), "R2 no update while shifting");
    pulseLe(w, "R2 commit on strobe");

    // R1: seven leading junk bits are pushed out, last 23 form the frame
    w = mkRef(1'b1, 2'b00, 14'h1234, 1'b1, 4'h0);
    shiftBits({2'b00, w, 7'b1011001}, 30);
    pulseLe(w, "R1 last 23 bits kept");

    // R2: strobe held high while a new frame shifts in
    w = mkMain(1'b1, 1'b0, 1'b0, 1'b1, 7'd17, 11'd777);
    shiftBits({9'd0, w}, 23);
    pulseLe(w, "R2 held strobe first commit", 1'b1);
    shiftBits({9'd0, mkMain(1'b1, 1'b1, 1'b1, 1'b0, 7'd1, 11'd9)}, 23);
    compare(modelVec(), "R2 held strobe no relatch");
    @(negedge clk); latchEn = 1'b0;
    @(negedge clk);

    // R7: asynchronous clear mid-run
    @(negedge clk); rstN = 1'b0;
    #1;
    clearModel();
    compare(modelVec(), "R7 async clear");
    @(negedge clk); rstN = 1'b1;
    sendWord(mkMain(1'b0, 1'b0, 1'b0, 1'b0, 7'd3, 11'd500), "R4 after reset");

    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule